// File: doc/BRIEF.md
# Three-Level Lookahead Adder with Increment Mode

This block is a purely combinational 64-bit adder. Its carries come from a lookahead tree, not a ripple chain. Every bit produces a generate and a propagate term. Radix-4 group cells merge those terms into 4-bit spans, then 16-bit spans, then one 64-bit span. Carry cells send the carry-in back down the same tree: first to each 16-bit span, then to each 4-bit span, then to each bit. Each sum bit is the bit propagate XOR the carry into that bit. No gate in the lookahead path takes more than four inputs.

A mode input turns the same hardware into an incrementer. In that mode the bit stage forces every generate to zero, passes the A bit through as the propagate and forces the carry-in high. The tree then reduces to chains of AND gates over propagates, and the result is A + 1. The width is set by the number of tree levels (`LEVELS`), with 4^LEVELS bits. The default is three levels and 64 bits.

Top module: `cla_inc64`

## Requirements
- R1: With `inc_mode` = 0, {`cout`, `sum`} equals the 65-bit value `a` + `b` + `cin` for any operands.
- R2: With `inc_mode` = 1, `sum` equals `a` + 1 modulo 2^64.
- R3: With `inc_mode` = 1, `cout` is 1 exactly when every bit of `a` is 1, and in that case `sum` is all zeros.
- R4: With `inc_mode` = 0, a carry-in that propagates through all 64 positions (`a` all ones, `b` = 0, `cin` = 1) yields `sum` = 0 and `cout` = 1. The same holds for `a` all ones, `b` = 1, `cin` = 0.
- R5: A carry produced below a 4-bit or 16-bit span boundary reaches the bit above it. For example, `a` = 2^(k+1) − 1, `b` = 0, `cin` = 1 gives `sum` = 2^(k+1) for k = 3, 15 and 47.
- R6: With `inc_mode` = 1, the values on `b` and `cin` have no effect on `sum` or `cout`.
- R7: With all inputs at zero, `sum` is 0 and `cout` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | 64 | First operand; the value incremented in increment mode |
| b | input | 64 | Second operand; ignored in increment mode |
| cin | input | 1 | Carry into bit 0; ignored in increment mode |
| inc_mode | input | 1 | 1 selects increment (A + 1), 0 selects full addition |
| sum | output | 64 | Result bits |
| cout | output | 1 | Carry out of bit 63 |

## Verification
The bench drives carry chains that stop just below a 4-bit boundary, a 16-bit boundary and the 48-bit point, and a chain that runs through all 64 bits. A carry cell wired to the wrong child, or a group term that drops a product, shows up there as a missing high bit or a stray low bit. In increment mode it holds `a` fixed and sweeps `b` and `cin`. A bit stage that lets generates or the carry-in leak through would return A + B or A + 2. The all-ones increment checks the wrap to zero with the carry-out raised. Random operands and alternating-bit patterns in both modes catch swapped propagate and generate terms.

// File: rtl/cla_pkg.sv
// Package: shared sizing helpers for the radix-4 lookahead tree.
// Assumes the tree radix is fixed at four and the width is 4**levels.
package cla_pkg;

    localparam int RADIX = 4;

    typedef logic [RADIX-1:0] quad_t;

    // Number of nodes on tree level lvl (level 0 = individual bits).
    function automatic int lvl_nodes(input int lvl, input int width);
        return width >> (2 * lvl);
    endfunction

    // Index of the first node of level lvl in the flat node vector.
    function automatic int lvl_off(input int lvl, input int width);
        int acc;
        acc = 0;
        for (int i = 0; i < lvl; i++) begin
            acc += width >> (2 * i);
        end
        return acc;
    endfunction

endpackage

// File: rtl/cla_bitpg.sv
// Module: bit stage. Forms bit generate/propagate and the effective carry-in.
// Assumes: in increment mode B and the carry-in are discarded, every
// generate is forced low and the propagate equals the A bit.
module cla_bitpg #(
    parameter int WIDTH = 64
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             cin,
    input  logic             inc_mode,
    output logic [WIDTH-1:0] g,
    output logic [WIDTH-1:0] p,
    output logic             c0
);

    // Per-bit generate and propagate, with the mode folded in.
    always_comb begin
        for (int i = 0; i < WIDTH; i++) begin
            g[i] = ~inc_mode & a[i] & b[i];
            p[i] = inc_mode ? a[i] : (a[i] ^ b[i]);
        end
    end

    // Carry into bit 0: forced high when incrementing.
    always_comb begin
        c0 = inc_mode | cin;
    end

endmodule

// File: rtl/cla_group4.sv
// Module: radix-4 group cell. Merges four child generate/propagate pairs
// into one parent pair. Assumes child 3 is the most significant.
// Each gate has at most four inputs.
module cla_group4 (
    input  cla_pkg::quad_t g_in,
    input  cla_pkg::quad_t p_in,
    output logic           g_out,
    output logic           p_out
);

    // Parent generate: a child generates and all higher children propagate.
    always_comb begin
        g_out = g_in[3]
              | (p_in[3] & g_in[2])
              | (p_in[3] & p_in[2] & g_in[1])
              | (p_in[3] & p_in[2] & p_in[1] & g_in[0]);
    end

    // Parent propagate: all four children propagate.
    always_comb begin
        p_out = p_in[3] & p_in[2] & p_in[1] & p_in[0];
    end

endmodule

// File: rtl/cla_carry4.sv
// Module: radix-4 carry cell. Takes the carry into a parent span and the
// lower three children's generate/propagate pairs. Produces the carry into
// each of the four children. Every gate has at most four inputs.
module cla_carry4 (
    input  logic       cin,
    input  logic [2:0] g_in,
    input  logic [2:0] p_in,
    output logic [3:0] c_out
);

    // Lookahead carries into children 0..3 of the span.
    always_comb begin
        c_out[0] = cin;
        c_out[1] = g_in[0] | (p_in[0] & cin);
        c_out[2] = g_in[1]
                 | (p_in[1] & g_in[0])
                 | (p_in[1] & p_in[0] & cin);
        c_out[3] = g_in[2]
                 | (p_in[2] & g_in[1])
                 | (p_in[2] & p_in[1] & g_in[0])
                 | (p_in[2] & p_in[1] & p_in[0] & cin);
    end

endmodule

// File: rtl/cla_sumxor.sv
// Module: sum stage. Each result bit is the bit propagate XOR the carry
// into that bit. Assumes p already holds the A bit in increment mode.
module cla_sumxor #(
    parameter int WIDTH = 64
) (
    input  logic [WIDTH-1:0] p,
    input  logic [WIDTH-1:0] c,
    output logic [WIDTH-1:0] s
);

    // Bitwise sum formation.
    always_comb begin
        s = p ^ c;
    end

endmodule

// File: rtl/cla_inc64.sv
// Module: top of the lookahead adder/incrementer.
// All generate, propagate and carry terms live in one flat node vector,
// ordered level by level: bits first, then 4-bit, 16-bit and 64-bit spans.
// Group cells build the tree upward. Carry cells hand carries back down.
// Assumes a purely combinational context; there is no clock or reset.
module cla_inc64 #(
    parameter  int LEVELS = 3,
    localparam int WIDTH  = 1 << (2 * LEVELS)
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             cin,
    input  logic             inc_mode,
    output logic [WIDTH-1:0] sum,
    output logic             cout
);

    localparam int TOTAL = cla_pkg::lvl_off(LEVELS + 1, WIDTH);
    localparam int TOPI  = cla_pkg::lvl_off(LEVELS, WIDTH);

    logic [TOTAL-1:0] g_all;
    logic [TOTAL-1:0] p_all;
    logic [TOTAL-1:0] c_all;
    logic             c0;
    logic             top_g;
    logic             top_p;

    // Level 0: bit generate/propagate and the effective carry-in.
    cla_bitpg #(.WIDTH(WIDTH)) u_bitpg (
        .a        (a),
        .b        (b),
        .cin      (cin),
        .inc_mode (inc_mode),
        .g        (g_all[WIDTH-1:0]),
        .p        (p_all[WIDTH-1:0]),
        .c0       (c0)
    );

    // Upward pass: one group cell per node on levels 1..LEVELS.
    for (genvar l = 1; l <= LEVELS; l++) begin : g_up
        for (genvar k = 0; k < cla_pkg::lvl_nodes(l, WIDTH); k++) begin : g_node
            localparam int CB = cla_pkg::lvl_off(l - 1, WIDTH) + 4 * k;
            localparam int NI = cla_pkg::lvl_off(l, WIDTH) + k;
            cla_group4 u_grp (
                .g_in  (g_all[CB +: 4]),
                .p_in  (p_all[CB +: 4]),
                .g_out (g_all[NI]),
                .p_out (p_all[NI])
            );
        end
    end

    // Root carry: the carry entering the whole word.
    assign c_all[TOPI] = c0;

    // Downward pass: one carry cell per node, feeding its four children.
    for (genvar l = LEVELS; l >= 1; l--) begin : g_down
        for (genvar k = 0; k < cla_pkg::lvl_nodes(l, WIDTH); k++) begin : g_node
            localparam int CB = cla_pkg::lvl_off(l - 1, WIDTH) + 4 * k;
            localparam int NI = cla_pkg::lvl_off(l, WIDTH) + k;
            cla_carry4 u_car (
                .cin   (c_all[NI]),
                .g_in  (g_all[CB +: 3]),
                .p_in  (p_all[CB +: 3]),
                .c_out (c_all[CB +: 4])
            );
        end
    end

    // Sum bits from bit propagates and bit carries.
    cla_sumxor #(.WIDTH(WIDTH)) u_sum (
        .p (p_all[WIDTH-1:0]),
        .c (c_all[WIDTH-1:0]),
        .s (sum)
    );

    // Root group terms and the carry out of the top bit.
    assign top_g = g_all[TOPI];
    assign top_p = p_all[TOPI];
    assign cout  = top_g | (top_p & c0);

endmodule

// File: rtl/cla_inc64_chk.sv
// Module: checker for cla_inc64. It compares the ports against arithmetic
// reference relations and inspects the root group terms. It uses immediate
// assertions because the block has no clock.
module cla_inc64_chk #(
    parameter int WIDTH = 64
) (
    input logic [WIDTH-1:0] a,
    input logic [WIDTH-1:0] b,
    input logic             cin,
    input logic             inc_mode,
    input logic [WIDTH-1:0] sum,
    input logic             cout,
    input logic             top_g,
    input logic             top_p
);

    logic [WIDTH:0] ref_add;
    logic [WIDTH:0] ref_inc;

    // Reference values for both modes.
    always_comb begin
        ref_add = {1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, cin};
        ref_inc = {1'b0, a} + {{WIDTH{1'b0}}, 1'b1};
    end

    // Port and root-node relations.
    always_comb begin
        if (!inc_mode) begin
            AST_ADD_RESULT: assert ({cout, sum} == ref_add) else $error("add mismatch"); // R1
            AST_ROOT_PROPAGATE: assert (top_p == (&(a ^ b))) else $error("root propagate"); // R4
        end
        if (inc_mode) begin
            AST_INC_RESULT: assert (sum == ref_inc[WIDTH-1:0]) else $error("inc mismatch"); // R2
            AST_INC_WRAP: assert (cout == (&a)) else $error("inc carry-out"); // R3
            AST_INC_NO_GENERATE: assert (!top_g) else $error("generate leaked"); // R6
        end
    end

endmodule

bind cla_inc64 cla_inc64_chk #(.WIDTH(WIDTH)) u_chk (
    .a        (a),
    .b        (b),
    .cin      (cin),
    .inc_mode (inc_mode),
    .sum      (sum),
    .cout     (cout),
    .top_g    (top_g),
    .top_p    (top_p)
);

// File: tb/sim_cla_inc64.sv
// Bench: directed tests for cla_inc64, one task per scenario.
// Inputs change after a rising edge; results are sampled 2 ns later.
module sim_cla_inc64;

    localparam int W = 64;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] a = '0;
    logic [W-1:0] b = '0;
    logic         cin = 1'b0;
    logic         inc_mode = 1'b0;
    logic [W-1:0] sum;
    logic         cout;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    cla_inc64 u0 (
        .a        (a),
        .b        (b),
        .cin      (cin),
        .inc_mode (inc_mode),
        .sum      (sum),
        .cout     (cout)
    );

    // 125 MHz clock paces the stimulus.
    always #4 clk = ~clk;

    // Apply one vector and let it settle.
    task automatic drive(input logic [W-1:0] av, input logic [W-1:0] bv,
                         input logic ci, input logic im);
        @(posedge clk);
        #1;
        a = av; b = bv; cin = ci; inc_mode = im;
        #2;
    endtask

    // Compare {cout,sum} with an expected 65-bit value.
    task automatic check(input string req, input logic [W:0] exp);
        n_checks++;
        if ({cout, sum} !== exp) begin
            n_errors++;
            $display("FAIL %s: got %h expected %h", req, {cout, sum}, exp);
        end
    endtask

    function automatic logic [W:0] add_ref(input logic [W-1:0] x,
                                           input logic [W-1:0] y, input logic c);
        return {1'b0, x} + {1'b0, y} + {{W{1'b0}}, c};
    endfunction

    function automatic logic [W-1:0] rnd64();
        return {$urandom, $urandom};
    endfunction

    // R7: all-zero inputs.
    task automatic t_zero();
        drive('0, '0, 1'b0, 1'b0);
        check("R7", '0);
    endtask

    // R1: random and patterned operands in add mode.
    task automatic t_add_mix();
        logic [W-1:0] alt;
        alt = {(W/2){2'b10}};
        for (int i = 0; i < 40; i++) begin
            logic [W-1:0] x, y;
            logic c;
            x = rnd64(); y = rnd64(); c = 1'($urandom);
            drive(x, y, c, 1'b0);
            check("R1", add_ref(x, y, c));
        end
        drive(alt, ~alt, 1'b0, 1'b0);
        check("R1", add_ref(alt, ~alt, 1'b0));
        drive(alt, ~alt, 1'b1, 1'b0);
        check("R1", add_ref(alt, ~alt, 1'b1));
        drive(alt, alt, 1'b1, 1'b0);
        check("R1", add_ref(alt, alt, 1'b1));
    endtask

    // R4: carry through the entire word.
    task automatic t_full_chain();
        drive('1, '0, 1'b1, 1'b0);
        check("R4", {1'b1, {W{1'b0}}});
        drive('1, {{(W-1){1'b0}}, 1'b1}, 1'b0, 1'b0);
        check("R4", {1'b1, {W{1'b0}}});
    endtask

    // R5: carries crossing the 4-bit, 16-bit and 48-bit points.
    task automatic t_boundaries();
        int ks[3] = '{3, 15, 47};
        foreach (ks[i]) begin
            logic [W-1:0] x;
            logic [W:0] e;
            x = (64'd1 << (ks[i] + 1)) - 64'd1;
            e = {1'b0, 64'd1 << (ks[i] + 1)};
            drive(x, '0, 1'b1, 1'b0);
            check("R5", e);
        end
    endtask

    // R2: increment on random and patterned operands.
    task automatic t_inc();
        for (int i = 0; i < 30; i++) begin
            logic [W-1:0] x;
            x = rnd64();
            drive(x, rnd64(), 1'($urandom), 1'b1);
            check("R2", add_ref(x, '0, 1'b1));
        end
        drive({(W/2){2'b01}}, '0, 1'b0, 1'b1);
        check("R2", add_ref({(W/2){2'b01}}, '0, 1'b1));
        drive(64'h0000_0000_FFFF_FFFF, '0, 1'b0, 1'b1);
        check("R2", {1'b0, 64'h0000_0001_0000_0000});
    endtask

    // R3: increment wraps from all ones.
    task automatic t_inc_wrap();
        drive('1, '0, 1'b0, 1'b1);
        check("R3", {1'b1, {W{1'b0}}});
        drive({1'b0, {(W-1){1'b1}}}, '0, 1'b0, 1'b1);
        check("R3", {1'b0, 1'b1, {(W-1){1'b0}}});
    endtask

    // R6: b and cin have no influence in increment mode.
    task automatic t_inc_ignore();
        logic [W-1:0] x;
        x = 64'h1234_5678_9ABC_DEF0;
        drive(x, '1, 1'b1, 1'b1);
        check("R6", add_ref(x, '0, 1'b1));
        drive(x, '1, 1'b0, 1'b1);
        check("R6", add_ref(x, '0, 1'b1));
        drive(x, 64'h0F0F_0F0F_0F0F_0F0F, 1'b1, 1'b1);
        check("R6", add_ref(x, '0, 1'b1));
    endtask

    // Watchdog: ends a hung run as a failure.
    initial begin
        #1000000;
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    // Main sequence.
    initial begin
        repeat (2) @(posedge clk);
        rst_n = 1'b1;
        t_zero();
        t_add_mix();
        t_full_chain();
        t_boundaries();
        t_inc();
        t_inc_wrap();
        t_inc_ignore();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule